// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the synchronous address front end of a burst-capable static memory. On a clock edge where an address strobe is accepted, it registers an external word address. It then walks the two lowest address bits through a four-beat burst, one step for each cycle in which the advance input is asserted. The sequence follows either a linear or an interleaved order, and a static mode pin picks which one. The block also registers a single "selected" flag from the chip enable and the two chip selects.

There are two strobes. The controller-side strobe always loads an address. The processor-side strobe loads only while chip enable is active. The memory array is driven from the word address output and the selected flag.

Top module: `burst_addr_seq`

## Requirements
- R1: When `adsc_n` is 0 at a rising clock edge, the base address register takes `addr_in`, and `word_addr` shows that address after the edge.
- R2: When `adsp_n` is 0 and `ce_n` is 0 at an edge, the address loads as in R1. When `adsp_n` is 0, `ce_n` is 1 and `adsc_n` is 1, the strobe is ignored and `word_addr` stays unchanged.
- R3: Every accepted load resets the burst count to zero. A load and `adv_n`=0 in the same cycle give a count of zero, so the load wins.
- R4: When no load occurs, `adv_n`=0 increments the 2-bit burst count modulo 4 and `adv_n`=1 holds it.
- R5: With `burst_ilv`=0 (linear), the low two bits of `word_addr` equal the loaded low bits plus the count, modulo 4.
- R6: With `burst_ilv`=1 (interleaved), the low two bits of `word_addr` equal the loaded low bits XOR the count.
- R7: Bits above bit 1 of `word_addr` stay equal to the loaded address for the whole burst. A wrap of the low bits never carries into them.
- R8: `selected` is registered on every accepted load as (`ce_n`==0 and `cs0`==1 and `cs1_n`==0), and it holds between loads.
- R9: While reset is asserted, and after reset until the first load, `word_addr` is 0 and `selected` is 0. `rst_n` asserts the reset asynchronously and releases it through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr_in | input | ADDR_W (17) | External word address |
| adsc_n | input | 1 | Controller address strobe, active low |
| adsp_n | input | 1 | Processor address strobe, active low, qualified by ce_n |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| word_addr | output | ADDR_W (17) | Current memory word address |
| selected | output | 1 | Registered select flag |

## Verification
The assertions assume that every input is sampled synchronously at the rising edge. They also assume that `burst_ilv` changes only between bursts, because the low-bit mapping is combinational from the mode pin. The stimulus drives all inputs on the falling edge. It changes `burst_ilv` only in cycles that also load a new address, so each burst runs entirely in one order. The random phase mixes strobes, advance and selects freely, and every output is predicted by a reference model in the bench.

// File: rtl/burst_addr_pkg.sv
`timescale 1ns/1ps
package burst_addr_pkg;
  localparam int unsigned BEAT_BITS = 2;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVED = 1'b1} burst_order_e;

  function automatic logic [BEAT_BITS-1:0] beat_map(
    input logic [BEAT_BITS-1:0] base_lo,
    input logic [BEAT_BITS-1:0] count,
    input burst_order_e         ord
  );
    logic [BEAT_BITS-1:0] res;
    if (ord == ORD_INTERLEAVED) res = base_lo ^ count;
    else                        res = base_lo + count;
    return res;
  endfunction
endpackage

// File: rtl/burst_rst_sync.sv
`timescale 1ns/1ps
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/burst_addr_capture.sv
`timescale 1ns/1ps
module burst_addr_capture #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adsc_n,
  input  logic              adsp_n,
  input  logic              ce_n,
  output logic              load,
  output logic [ADDR_W-1:0] base_q
);
  logic              ctrl_strobe;
  logic              proc_strobe;
  logic [ADDR_W-1:0] base_d;

  assign ctrl_strobe = !adsc_n;
  assign proc_strobe = !adsp_n && !ce_n;
  assign load        = ctrl_strobe || proc_strobe;

  always_comb begin
    base_d = base_q;
    if (load) base_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  // R2
  adsp_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce_n && adsc_n) |=> $stable(base_q));

  // R1
  adsc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adsc_n |=> (base_q == $past(addr_in)));
endmodule

// File: rtl/burst_counter.sv
`timescale 1ns/1ps
module burst_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv_n,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             step_en;

  assign step_en = !adv_n && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = '0;
    else if (step_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));

  // R4
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_sel_reg.sv
`timescale 1ns/1ps
module burst_sel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ce_n,
  input  logic cs0,
  input  logic cs1_n,
  output logic sel_q
);
  logic chip_hit;
  logic sel_d;

  assign chip_hit = !ce_n && cs0 && !cs1_n;

  always_comb begin
    sel_d = sel_q;
    if (load) sel_d = chip_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));

  // R8
  sel_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (ce_n || !cs0 || cs1_n)) |=> !sel_q);
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adsc_n,
  input  logic              adsp_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              cs0,
  input  logic              cs1_n,
  input  logic              burst_ilv,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected
);
  localparam int unsigned HI_W = ADDR_W - BEAT_BITS;

  logic                 rst_n_sync;
  logic                 load;
  logic [ADDR_W-1:0]    base_q;
  logic [BEAT_BITS-1:0] cnt_q;
  burst_order_e         ord;

  assign ord = burst_order_e'(burst_ilv);

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  burst_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n_sync), .addr_in(addr_in),
    .adsc_n(adsc_n), .adsp_n(adsp_n), .ce_n(ce_n),
    .load(load), .base_q(base_q)
  );

  burst_counter #(.CNT_W(BEAT_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .load(load), .adv_n(adv_n), .cnt_q(cnt_q)
  );

  burst_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n_sync), .load(load),
    .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n), .sel_q(selected)
  );

  assign word_addr = {base_q[ADDR_W-1:BEAT_BITS],
                      beat_map(base_q[BEAT_BITS-1:0], cnt_q, ord)};

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !load |=> $stable(word_addr[ADDR_W-1:BEAT_BITS]));

  // R3
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    load |=> (word_addr == $past(addr_in)));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int unsigned AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic adsc_n, adsp_n, adv_n, ce_n, cs0, cs1_n, burst_ilv;
  logic [AW-1:0] word_addr;
  logic          selected;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_base = '0;
  int unsigned   m_cnt  = 0;
  logic          m_sel  = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adsc_n(adsc_n),
    .adsp_n(adsp_n), .adv_n(adv_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
    .burst_ilv(burst_ilv), .word_addr(word_addr), .selected(selected)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                             input int unsigned c,
                                             input logic ilv);
    logic [1:0] lo;
    if (ilv) lo = b[1:0] ^ 2'(c);
    else     lo = 2'((int'(b[1:0]) + c) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [AW-1:0] e;
    e = exp_addr(m_base, m_cnt, burst_ilv);
    chk(word_addr === e, tag, 32'(word_addr), 32'(e));
    chk(selected === m_sel, "R8", 32'(selected), 32'(m_sel));
  endtask

  task automatic step(input logic a_c, input logic a_p, input logic ce,
                      input logic s0, input logic s1, input logic adv,
                      input logic [AW-1:0] a, input string tag);
    logic ld;
    @(negedge clk);
    adsc_n = a_c; adsp_n = a_p; ce_n = ce; cs0 = s0; cs1_n = s1;
    adv_n = adv; addr_in = a;
    @(posedge clk);
    #2;
    ld = !a_c || (!a_p && !ce);
    if (ld) begin
      m_base = a; m_cnt = 0; m_sel = !ce && s0 && !s1;
    end else if (!adv) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    check_outs(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; addr_in = '0; adsc_n = 1; adsp_n = 1; adv_n = 1;
    ce_n = 1; cs0 = 0; cs1_n = 1; burst_ilv = 0;
    repeat (3) @(posedge clk);
    #2;
    check_outs("R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check_outs("R9");

    // R1 controller strobe load, linear, base low = 1
    step(0, 1, 1, 0, 1, 1, 17'h0A5A5, "R1");
    // R5 linear burst 1,2,3,0
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R5");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R5");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R5");
    // R4 hold
    step(1, 1, 0, 1, 0, 1, 17'h1FFFF, "R4");
    // R4 wrap back to beat 0
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R4");

    // R2 processor strobe with chip enable: loads and selects
    step(1, 0, 0, 1, 0, 1, 17'h13579, "R2");
    // R2 processor strobe without chip enable: ignored
    step(1, 0, 1, 1, 0, 1, 17'h02468, "R2");
    // R3 load and advance together
    step(0, 1, 0, 1, 0, 0, 17'h1FFFF, "R3");
    // R7 upper bits stay through wrap from low = 3
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R7");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R7");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R7");
    // R8 deselect via cs1_n high on a load
    step(0, 1, 0, 1, 1, 1, 17'h00101, "R8");

    // R6 interleaved from low = 1: 1,0,3,2
    @(negedge clk); burst_ilv = 1;
    step(0, 1, 0, 1, 0, 1, 17'h04441, "R6");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R6");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R6");
    step(1, 1, 1, 0, 1, 0, 17'h00000, "R6");

    // random phase; mode changes only with a load
    for (int i = 0; i < 400; i++) begin
      logic a_c, a_p, ce, s0, s1, adv;
      a_c = ($urandom % 4) == 0;
      a_c = !a_c;
      a_p = $urandom % 2;
      ce  = $urandom % 2;
      s0  = $urandom % 2;
      s1  = $urandom % 2;
      adv = $urandom % 2;
      if (!a_c && ($urandom % 3) == 0) begin
        @(negedge clk);
        burst_ilv = $urandom % 2;
      end
      step(a_c, a_p, ce, s0, s1, adv, 17'($urandom),
           burst_ilv ? "R6" : "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule